// File: doc/BRIEF.md
# Codec Serial Frame Port

This block is the codec side of a synchronous serial link. One output pin and one input pin carry data in both directions at the same time. The block divides the system clock to produce the serial bit clock and marks slots with a frame strobe. Every frame is `FRAME_LEN` bit clocks long, and the frame rate equals the audio sample rate.

A 16-bit audio slot opens every frame. On the input side, the last bit of that slot is not audio. When it is 1, it requests a register-access slot at mid-frame, in the same frame. That slot carries one command word. Bit 13 selects read (1) or write (0). Bits [12:8] hold a register address. Bits [7:0] hold write data, and on a read they carry the returned byte. Bits [15:14] are ignored.

The register file itself sits outside the block. It is reached through a one-cycle-latency read/write port that maps naturally onto block RAM. A two-bit strap input sets how the frame strobe behaves and how the last outgoing audio bit is handled.

Top module: `codec_frame_port`

## Requirements
- R1: `sclk` toggles every `SCLK_DIV` clock cycles. A frame spans `FRAME_LEN` sclk periods with bit positions 0 to `FRAME_LEN`-1. The audio slot occupies positions 0 to 15, and the access slot starts at position `FRAME_LEN`/2. At any position outside an active slot, `sdo` is 0.
- R2: `sdo` changes only on rising `sclk`. In the audio slot it sends `tx_sample` MSB first, and that word is captured at the rising edge that begins position 0.
- R3: In mode 2 the audio-slot bit at position 15 is driven 0. In modes 0 and 1 all 16 bits of `tx_sample` are sent.
- R4: `sdi` is sampled on falling `sclk`. After position 15, `rx_sample` holds the first 15 received bits, MSB first, and `rx_valid` pulses for one clock, once per frame.
- R5: A 1 in the audio-slot LSB on `sdi` opens the access slot in the same frame. When that bit is 0, the mid-frame position is ignored: no register strobe occurs and `sdo` stays 0 there.
- R6: An access word with bit 13 = 0 gives exactly one `reg_wr` pulse. That pulse carries address bits [12:8] and data bits [7:0]. Bits [15:14] have no effect.
- R7: An access word with bit 13 = 1 gives exactly one `reg_rd` pulse for address bits [12:8]. The returned byte is sent on `sdo` in slot bits [7:0], MSB first, and slot bits [15:8] are 0.
- R8: In modes 0 and 2, `fsync` is high for the 16 bit periods of each active slot. In mode 1, `fsync` is high only for the single bit period just before each active slot (position `FRAME_LEN`-1 and position `FRAME_LEN`/2-1).
- R9: Mode 3 keeps `fsync` and `sdo` low, produces no `rx_valid` and performs no register access.
- R10: During reset, `sclk`, `fsync`, `sdo`, `rx_valid`, `reg_rd` and `reg_wr` are 0. The first rising `sclk` after reset begins position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Strap mode: 0 strobe spans slot, 1 strobe pulse before slot, 2 as 0 with audio LSB zero, 3 port off |
| tx_sample | input | 16 | Audio word to send, captured at frame start |
| rx_sample | output | 15 | Received audio bits |
| rx_valid | output | 1 | One-clock pulse when `rx_sample` updates |
| sclk | output | 1 | Serial bit clock |
| fsync | output | 1 | Slot strobe |
| sdi | input | 1 | Serial data from the controller |
| sdo | output | 1 | Serial data to the controller |
| reg_addr | output | 5 | Register address |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, valid one clock after `reg_rd` |

## Verification
The bench builds the port with `FRAME_LEN` = 64 and `SCLK_DIV` = 3. With these values a whole frame takes 384 clocks, so many complete frames fit in a short run, including mode changes, write-then-read sequences and a reset in mid-frame. `SCLK_DIV` = 3 is the smallest divider the one-cycle read path allows, so read data reaches `sdo` with no slack at all. The mid-frame slot at position 32 still sits well clear of the audio slot.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  typedef enum logic [1:0] {
    MODE_GATE  = 2'd0,
    MODE_PULSE = 2'd1,
    MODE_SLAVE = 2'd2,
    MODE_OFF   = 2'd3
  } cfp_mode_e;

  localparam int CFP_WORD_W = 16;
  localparam int CFP_ADDR_W = 5;
  localparam int CFP_DATA_W = 8;
endpackage

// File: rtl/cfp_timebase.sv
module cfp_timebase #(
  parameter int FRAME_LEN = 256,
  parameter int SCLK_DIV  = 4,
  localparam int PW = $clog2(FRAME_LEN),
  localparam int DW = $clog2(SCLK_DIV + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          sclk,
  output logic          rise_stb,
  output logic          fall_stb,
  output logic [PW-1:0] pos,
  output logic [PW-1:0] pos_nxt
);
  localparam logic [PW-1:0] P_LAST = PW'(FRAME_LEN - 1);
  localparam logic [DW-1:0] D_LAST = DW'(SCLK_DIV - 1);

  logic [DW-1:0] dcnt;
  logic          tick;

  assign tick     = (dcnt == D_LAST);
  assign rise_stb = tick & ~sclk;
  assign fall_stb = tick & sclk;
  assign pos_nxt  = (pos == P_LAST) ? '0 : pos + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt <= '0;
      sclk <= 1'b0;
      pos  <= P_LAST;
    end else begin
      dcnt <= tick ? '0 : dcnt + 1'b1;
      if (tick) sclk <= ~sclk;
      if (rise_stb) pos <= pos_nxt;
    end
  end
endmodule

// File: rtl/cfp_rx.sv
module cfp_rx
  import cfp_pkg::*;
#(
  parameter int FRAME_LEN = 256,
  parameter int WORD_W    = CFP_WORD_W,
  parameter int ADDR_W    = CFP_ADDR_W,
  parameter int DATA_W    = CFP_DATA_W,
  localparam int PW = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  cfp_mode_e         mode,
  input  logic              fall_stb,
  input  logic [PW-1:0]     pos,
  input  logic              sdi,
  output logic [WORD_W-2:0] rx_sample,
  output logic              rx_valid,
  output logic              sec_act,
  output logic              sec_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata
);
  localparam int HALF = FRAME_LEN / 2;
  localparam logic [PW-1:0] P_PRI_LAST = PW'(WORD_W - 1);
  localparam logic [PW-1:0] P_HALF     = PW'(HALF);
  localparam logic [PW-1:0] P_HDR_END  = PW'(HALF + WORD_W - DATA_W - 1);
  localparam logic [PW-1:0] P_SEC_END  = PW'(HALF + WORD_W - 1);

  logic [WORD_W-2:0] rx_sh;
  logic              off, in_pri, in_sec;

  assign off    = (mode == MODE_OFF);
  assign in_pri = (pos <= P_PRI_LAST);
  assign in_sec = (pos >= P_HALF) && (pos <= P_SEC_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sh     <= '0;
      rx_sample <= '0;
      rx_valid  <= 1'b0;
      sec_act   <= 1'b0;
      sec_rd    <= 1'b0;
      reg_addr  <= '0;
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      rx_valid <= 1'b0;
      reg_rd   <= 1'b0;
      reg_wr   <= 1'b0;
      if (fall_stb && pos == P_PRI_LAST) sec_act <= sdi & ~off;
      if (fall_stb && !off) begin
        if (in_pri || (in_sec && sec_act))
          rx_sh <= {rx_sh[WORD_W-3:0], sdi};
        if (pos == P_PRI_LAST) begin
          rx_sample <= rx_sh;
          rx_valid  <= 1'b1;
        end
        if (sec_act && pos == P_HDR_END) begin
          sec_rd   <= rx_sh[ADDR_W-1];
          reg_rd   <= rx_sh[ADDR_W-1];
          reg_addr <= {rx_sh[ADDR_W-2:0], sdi};
        end
        if (sec_act && pos == P_SEC_END && !sec_rd) begin
          reg_wr    <= 1'b1;
          reg_wdata <= {rx_sh[DATA_W-2:0], sdi};
        end
      end
    end
  end
endmodule

// File: rtl/cfp_tx.sv
module cfp_tx
  import cfp_pkg::*;
#(
  parameter int FRAME_LEN = 256,
  parameter int WORD_W    = CFP_WORD_W,
  parameter int DATA_W    = CFP_DATA_W,
  localparam int PW  = $clog2(FRAME_LEN),
  localparam int IW  = $clog2(WORD_W),
  localparam int DIW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  cfp_mode_e         mode,
  input  logic              rise_stb,
  input  logic [PW-1:0]     pos_nxt,
  input  logic              sec_act,
  input  logic              sec_rd,
  input  logic [WORD_W-1:0] tx_sample,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              sdo,
  output logic              fsync
);
  localparam int HALF     = FRAME_LEN / 2;
  localparam int SEC_END  = HALF + WORD_W - 1;
  localparam int SEC_DATA = HALF + WORD_W - DATA_W;

  logic [WORD_W-1:0] tx_lat;
  logic [DATA_W-1:0] rd_lat;
  logic              rd_d;
  logic              sdo_n, fs_n;

  always_comb begin
    int pi;
    logic [WORD_W-1:0] word;
    logic in_pri, in_sec;
    pi     = int'(pos_nxt);
    word   = (pi == 0) ? tx_sample : tx_lat;
    in_pri = (pi < WORD_W);
    in_sec = sec_act && (pi >= HALF) && (pi <= SEC_END);
    sdo_n  = 1'b0;
    fs_n   = 1'b0;
    if (mode != MODE_OFF) begin
      if (in_pri) begin
        if (!(mode == MODE_SLAVE && pi == WORD_W - 1))
          sdo_n = word[IW'(WORD_W - 1 - pi)];
      end else if (in_sec && sec_rd && pi >= SEC_DATA) begin
        sdo_n = rd_lat[DIW'(SEC_END - pi)];
      end
      if (mode == MODE_PULSE)
        fs_n = (pi == FRAME_LEN - 1) || (sec_act && pi == HALF - 1);
      else
        fs_n = in_pri || in_sec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_lat <= '0;
      rd_lat <= '0;
      rd_d   <= 1'b0;
      sdo    <= 1'b0;
      fsync  <= 1'b0;
    end else begin
      rd_d <= reg_rd;
      if (rd_d) rd_lat <= reg_rdata;
      if (rise_stb) begin
        sdo   <= sdo_n;
        fsync <= fs_n;
        if (pos_nxt == '0) tx_lat <= tx_sample;
      end
    end
  end
endmodule

// File: rtl/codec_frame_port.sv
module codec_frame_port
  import cfp_pkg::*;
#(
  parameter int FRAME_LEN = 256,
  parameter int SCLK_DIV  = 4,
  parameter int WORD_W    = CFP_WORD_W,
  parameter int ADDR_W    = CFP_ADDR_W,
  parameter int DATA_W    = CFP_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic [WORD_W-1:0] tx_sample,
  output logic [WORD_W-2:0] rx_sample,
  output logic              rx_valid,
  output logic              sclk,
  output logic              fsync,
  input  logic              sdi,
  output logic              sdo,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int PW = $clog2(FRAME_LEN);

  cfp_mode_e     mode_e;
  logic          rise_stb, fall_stb, sec_act, sec_rd;
  logic [PW-1:0] pos, pos_nxt;

  assign mode_e = cfp_mode_e'(mode);

  cfp_timebase #(.FRAME_LEN(FRAME_LEN), .SCLK_DIV(SCLK_DIV)) u_tb (
    .clk(clk), .rst(rst), .sclk(sclk), .rise_stb(rise_stb),
    .fall_stb(fall_stb), .pos(pos), .pos_nxt(pos_nxt)
  );

  cfp_rx #(.FRAME_LEN(FRAME_LEN), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
           .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .mode(mode_e), .fall_stb(fall_stb), .pos(pos),
    .sdi(sdi), .rx_sample(rx_sample), .rx_valid(rx_valid),
    .sec_act(sec_act), .sec_rd(sec_rd), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata)
  );

  cfp_tx #(.FRAME_LEN(FRAME_LEN), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .mode(mode_e), .rise_stb(rise_stb),
    .pos_nxt(pos_nxt), .sec_act(sec_act), .sec_rd(sec_rd),
    .tx_sample(tx_sample), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .sdo(sdo), .fsync(fsync)
  );
endmodule

// File: rtl/codec_frame_port_chk.sv
module codec_frame_port_chk #(
  parameter int SCLK_DIV = 4
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       sclk,
  input logic       fsync,
  input logic       sdo,
  input logic       rx_valid,
  input logic       reg_rd,
  input logic       reg_wr
);
  initial AST_DIV_MIN: assert (SCLK_DIV >= 3); // R7

  AST_SDO_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> $rose(sclk)); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R4
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr); // R6
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> !reg_rd); // R7
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd && reg_wr)); // R6
  AST_FSYNC_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    !$stable(fsync) |-> $rose(sclk)); // R8
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($rose(sclk) && $past(mode) == 2'd3) |-> (!fsync && !sdo)); // R9
endmodule

bind codec_frame_port codec_frame_port_chk #(.SCLK_DIV(SCLK_DIV)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .sclk(sclk), .fsync(fsync),
  .sdo(sdo), .rx_valid(rx_valid), .reg_rd(reg_rd), .reg_wr(reg_wr)
);

// File: tb/codec_frame_port_tb.sv
`timescale 1ns/1ps
module codec_frame_port_tb;
  localparam int FL   = 64;
  localparam int DIV  = 3;
  localparam int HALF = FL / 2;
  localparam int NV   = 10;

  // {mode, tx word, audio-slot word (LSB = request), access word}
  localparam logic [49:0] VEC [NV] = '{
    {2'd0, 16'hA5C3, 16'h1234, 16'h0000},
    {2'd0, 16'h8001, 16'h8001, 16'h055A},
    {2'd0, 16'hFFFF, 16'h0003, 16'h2500},
    {2'd1, 16'h7E81, 16'h4441, 16'hDFC3},
    {2'd1, 16'h0F0F, 16'hAAAB, 16'h7F00},
    {2'd2, 16'hFFFF, 16'h5555, 16'h2000},
    {2'd2, 16'h1235, 16'h0000, 16'h0000},
    {2'd3, 16'hFFFF, 16'hFFFF, 16'h0500},
    {2'd0, 16'h0000, 16'h0001, 16'h2500},
    {2'd0, 16'hC001, 16'h8000, 16'h2500}
  };

  logic        clk = 1'b0, rst = 1'b1, sdi = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [15:0] tx_sample = '0;
  logic [14:0] rx_sample;
  logic        rx_valid, sclk, fsync, sdo, reg_rd, reg_wr;
  logic [4:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [7:0]  ram [32];
  logic [7:0]  exp_mem [32];
  logic [FL-1:0] got_sdo, got_fs;
  int n_valid = 0, n_rd = 0, n_wr = 0;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  codec_frame_port #(.FRAME_LEN(FL), .SCLK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .mode(mode), .tx_sample(tx_sample),
    .rx_sample(rx_sample), .rx_valid(rx_valid), .sclk(sclk), .fsync(fsync),
    .sdi(sdi), .sdo(sdo), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) ram[i] <= 8'(i * 7 + 3);
      reg_rdata <= '0;
    end else begin
      if (reg_wr) ram[reg_addr] <= reg_wdata;
      if (reg_rd) reg_rdata <= ram[reg_addr];
    end
    if (rx_valid) n_valid <= n_valid + 1;
    if (reg_rd)   n_rd    <= n_rd + 1;
    if (reg_wr)   n_wr    <= n_wr + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [1:0] m, input logic [15:0] tx,
                           input logic [15:0] pri, input logic [15:0] sec);
    mode = m;
    tx_sample = tx;
    for (int p = 0; p < FL; p++) begin
      @(posedge sclk);
      #1;
      got_sdo[p] = sdo;
      got_fs[p]  = fsync;
      if (p < 16) sdi = pri[15-p];
      else if (p >= HALF && p < HALF + 16) sdi = sec[15-(p-HALF)];
      else sdi = p[0];
    end
  endtask

  task automatic do_vec(input int i);
    logic [1:0]  m;
    logic [15:0] tx, pri, sec;
    logic [FL-1:0] e_sdo, e_fs, m_pri, m_sec;
    bit req, rd;
    int v0, r0, w0;
    {m, tx, pri, sec} = VEC[i];
    req = pri[0] && (m != 2'd3);
    rd  = sec[13];
    e_sdo = '0; e_fs = '0; m_pri = '0; m_sec = '0;
    for (int p = 0; p < FL; p++) begin
      if (p < 16) begin
        m_pri[p] = 1'b1;
        if (m != 2'd3 && !(m == 2'd2 && p == 15)) e_sdo[p] = tx[15-p];
      end
      if (p >= HALF && p < HALF + 16) begin
        m_sec[p] = 1'b1;
        if (req && rd && p >= HALF + 8) e_sdo[p] = exp_mem[sec[12:8]][HALF+15-p];
      end
      if (m == 2'd1) e_fs[p] = (p == FL - 1) || (req && p == HALF - 1);
      else if (m != 2'd3)
        e_fs[p] = (p < 16) || (req && p >= HALF && p < HALF + 16);
    end
    v0 = n_valid; r0 = n_rd; w0 = n_wr;
    run_frame(m, tx, pri, sec);
    // R2 R3 R9: audio slot on sdo
    check((got_sdo & m_pri) == (e_sdo & m_pri),
          m == 2'd3 ? "R9 sdo off" : (m == 2'd2 ? "R3 audio lsb" : "R2 audio slot"),
          got_sdo & m_pri, e_sdo & m_pri);
    // R5 R7: access slot on sdo
    check((got_sdo & m_sec) == (e_sdo & m_sec), (req && rd) ? "R7 read data" : "R5 idle slot",
          got_sdo & m_sec, e_sdo & m_sec);
    // R1: other positions idle
    check((got_sdo & ~(m_pri | m_sec)) == '0, "R1 idle positions",
          got_sdo & ~(m_pri | m_sec), '0);
    check(got_fs == e_fs, m == 2'd3 ? "R9 fsync off" : "R8 fsync", got_fs, e_fs);
    if (m != 2'd3) begin
      check(rx_sample == pri[15:1], "R4 rx sample", 64'(rx_sample), 64'(pri[15:1]));
      check(n_valid - v0 == 1, "R4 rx_valid count", 64'(n_valid - v0), 1);
    end else begin
      check(n_valid - v0 == 0, "R9 no rx_valid", 64'(n_valid - v0), 0);
    end
    check(n_rd - r0 == int'(req && rd), "R7 read strobes", 64'(n_rd - r0), 64'(req && rd));
    check(n_wr - w0 == int'(req && !rd), "R6 write strobes", 64'(n_wr - w0), 64'(req && !rd));
    if (req && !rd) exp_mem[sec[12:8]] = sec[7:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) exp_mem[i] = 8'(i * 7 + 3);
    repeat (5) @(posedge clk);
    #1;
    check({sclk, fsync, sdo, rx_valid, reg_rd, reg_wr} == '0, "R10 reset outputs",
          64'({sclk, fsync, sdo, rx_valid, reg_rd, reg_wr}), 0);
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < NV; i++) do_vec(i);
    // R10: reset in mid-frame, then realign to position 0
    mode = 2'd0;
    repeat (20) @(posedge sclk);
    @(negedge clk) rst = 1'b1;
    repeat (4) @(negedge clk);
    check({sclk, fsync, sdo, rx_valid, reg_rd, reg_wr} == '0, "R10 mid-frame reset",
          64'({sclk, fsync, sdo, rx_valid, reg_rd, reg_wr}), 0);
    for (int i = 0; i < 32; i++) exp_mem[i] = 8'(i * 7 + 3);
    rst = 1'b0;
    do_vec(0);
    do_vec(2);
    do_vec(1);
    do_vec(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule